// File: doc/BRIEF.md
# Pin Function and Output Level Controller

This block controls 54 general-purpose pins through a 32-bit register port. Each pin has a 3-bit function code, and ten codes are packed into each selection word. The pins form two banks: a low bank of 32 pins and a high bank of 22 pins. Each bank keeps a level register. Software never writes the level register directly. It raises bits through a set register and lowers them through a clear register. A pin's output line moves only when its level bit actually changes and its function code at that moment means output (code 1).

The controller also watches the codes of pins 48 to 53. When all six carry code 4, a sticky selector routes a removable-card interface to host controller B. When all six return to code 0, it routes the interface back to host controller A. Any other combination leaves the selector where it was. The selector drives a mux that carries clock, command and four data lines between the card and the chosen host. The host that is not chosen sees idle lines, all ones.

Offsets for event detection, edge and level enables, and pull control decode as valid. They read as zero and ignore writes. Any offset that does not decode raises a one-cycle error flag.

Top module: `gpio_fsel_ctrl`

## Requirements
- R1: Selection word n sits at offset 4n, for n from 0 to 5. Bits 3f+2:3f hold the code of pin 10n+f, for f from 0 to 9. Bits 31:30 read as zero.
- R2: Fields that map to pin 54 or higher are ignored on write and read back as zero. In word 5, only bits 11:0 are kept.
- R3: A write to offset 0x1C (low bank) or 0x20 (high bank, data bits 21:0) ORs the written data into that bank's level. Reads of these offsets return zero.
- R4: A write to offset 0x28 (low bank) or 0x2C (high bank) clears the written bits from that bank's level. Reads of these offsets return zero.
- R5: Offset 0x34 reads the low bank level. Offset 0x38 reads the high bank level in bits 21:0, with zeros above. Writes to either offset change nothing.
- R6: A pin's output changes only when its level bit changes and its code is 1. Level bits of pins with other codes still update. A later change of a pin's code alone does not move its output.
- R7: Word-aligned offsets from 0x40 to 0x9C read as zero, ignore writes and raise no error.
- R8: Every other offset raises the error flag for one cycle, one cycle after the strobe. This covers unaligned offsets, the gaps 0x18, 0x24, 0x30 and 0x3C, and anything above 0x9C. Reads of these offsets return zero.
- R9: On a read strobe, the read data and the valid flag appear one cycle later. The valid flag stays high for one cycle.
- R10: The selector moves to B when pins 48 to 53 all hold code 4. It moves to A when they all hold code 0. Otherwise it holds. It updates one cycle after the selection write takes effect.
- R11: The selected host drives the card's clock, command and data lines and receives the card's command and data lines. The other host receives all ones.
- R12: After reset, every code is 0, both levels and all pin outputs are 0, and host A is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Undecoded-offset flag |
| pin_o | output | 54 | Pin output lines |
| sel_b_o | output | 1 | 1 when host B owns the card |
| ha_clk_i | input | 1 | Host A card clock |
| ha_cmd_i | input | 1 | Host A command out |
| ha_dat_i | input | 4 | Host A data out |
| hb_clk_i | input | 1 | Host B card clock |
| hb_cmd_i | input | 1 | Host B command out |
| hb_dat_i | input | 4 | Host B data out |
| card_cmd_i | input | 1 | Command from the card |
| card_dat_i | input | 4 | Data from the card |
| card_clk_o | output | 1 | Clock to the card |
| card_cmd_o | output | 1 | Command to the card |
| card_dat_o | output | 4 | Data to the card |
| ha_cmd_o | output | 1 | Command returned to host A |
| ha_dat_o | output | 4 | Data returned to host A |
| hb_cmd_o | output | 1 | Command returned to host B |
| hb_dat_o | output | 4 | Data returned to host B |

## Verification
The properties assume that every access is a single-cycle strobe and that `req_i` stays low while reset is asserted. The selector-hold property looks back two cycles to the strobe, so it relies on no access arriving during reset. The bench drives each access for exactly one cycle and leaves an idle cycle after every write, so the selector update always falls inside a quiet window. Random selection data is biased toward codes 0, 1 and 4, so that output gating and both selector transitions occur often.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;
  localparam int NUM_PINS  = 54;
  localparam int LOW_W     = 32;
  localparam int HIGH_W    = NUM_PINS - LOW_W;
  localparam int FW        = 3;
  localparam int FPW       = 10;
  localparam int NUM_FREG  = (NUM_PINS + FPW - 1) / FPW;
  localparam int AW        = 12;
  localparam int DW        = 32;
  localparam int IDXW      = $clog2(NUM_FREG);
  localparam int CARD_PIN0 = 48;
  localparam int CARD_N    = 6;
  localparam int CARD_DW   = 4;

  localparam logic [FW-1:0] CODE_OUT = 3'd1;
  localparam logic [FW-1:0] CODE_A   = 3'd0;
  localparam logic [FW-1:0] CODE_B   = 3'd4;

  localparam logic [AW-1:0] OFS_FSEL_LAST = 12'h014;
  localparam logic [AW-1:0] OFS_SET_LO    = 12'h01C;
  localparam logic [AW-1:0] OFS_SET_HI    = 12'h020;
  localparam logic [AW-1:0] OFS_CLR_LO    = 12'h028;
  localparam logic [AW-1:0] OFS_CLR_HI    = 12'h02C;
  localparam logic [AW-1:0] OFS_LEV_LO    = 12'h034;
  localparam logic [AW-1:0] OFS_LEV_HI    = 12'h038;
  localparam logic [AW-1:0] OFS_RSVD_LO   = 12'h040;
  localparam logic [AW-1:0] OFS_RSVD_HI   = 12'h09C;

  typedef enum logic [3:0] {
    ACC_FSEL, ACC_SET_LO, ACC_SET_HI, ACC_CLR_LO, ACC_CLR_HI,
    ACC_LEV_LO, ACC_LEV_HI, ACC_RSVD, ACC_BAD
  } acc_kind_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_fsel_pkg::*;
(
  input  logic [AW-1:0]   addr_i,
  output acc_kind_e       kind_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    kind_o = ACC_BAD;
    idx_o  = addr_i[IDXW+1:2];
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i <= OFS_FSEL_LAST) kind_o = ACC_FSEL;
      else if (addr_i >= OFS_RSVD_LO && addr_i <= OFS_RSVD_HI) kind_o = ACC_RSVD;
      else begin
        unique case (addr_i)
          OFS_SET_LO: kind_o = ACC_SET_LO;
          OFS_SET_HI: kind_o = ACC_SET_HI;
          OFS_CLR_LO: kind_o = ACC_CLR_LO;
          OFS_CLR_HI: kind_o = ACC_CLR_HI;
          OFS_LEV_LO: kind_o = ACC_LEV_LO;
          OFS_LEV_HI: kind_o = ACC_LEV_HI;
          default:    kind_o = ACC_BAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_fsel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [FPW*FW-1:0] wdata_i,
  output logic [DW-1:0]     rword_o,
  output logic [NUM_PINS-1:0] is_out_o,
  output logic              card_all_a_o,
  output logic              card_all_b_o
);
  logic [NUM_PINS*FW-1:0] code_flat;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int R = p / FPW;
    localparam int F = p % FPW;
    logic [FW-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q <= '0;
      else if (wr_en_i && (int'(idx_i) == R)) code_q <= wdata_i[F*FW +: FW];
    end
    assign code_flat[p*FW +: FW] = code_q;
    assign is_out_o[p] = (code_q == CODE_OUT);
  end

  always_comb begin
    rword_o = '0;
    for (int f = 0; f < FPW; f++) begin
      if (int'(idx_i) * FPW + f < NUM_PINS)
        rword_o[f*FW +: FW] = code_flat[(int'(idx_i) * FPW + f) * FW +: FW];
    end
  end

  always_comb begin
    card_all_a_o = 1'b1;
    card_all_b_o = 1'b1;
    for (int c = 0; c < CARD_N; c++) begin
      if (code_flat[(CARD_PIN0 + c) * FW +: FW] != CODE_A) card_all_a_o = 1'b0;
      if (code_flat[(CARD_PIN0 + c) * FW +: FW] != CODE_B) card_all_b_o = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_level_bank.sv
module gpio_level_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] is_out_i,
  output logic [W-1:0] lev_o,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] lev_q, lev_d, pin_q, pin_d, upd;

  always_comb begin
    lev_d = lev_q;
    if (set_i)      lev_d = lev_q | wdata_i;
    else if (clr_i) lev_d = lev_q & ~wdata_i;
    // outputs follow only real level transitions on output-coded pins
    upd   = (lev_d ^ lev_q) & is_out_i;
    pin_d = (pin_q & ~upd) | (lev_d & upd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lev_q <= '0;
      pin_q <= '0;
    end else begin
      lev_q <= lev_d;
      pin_q <= pin_d;
    end
  end

  assign lev_o = lev_q;
  assign pin_o = pin_q;
endmodule

// File: rtl/gpio_card_sel.sv
module gpio_card_sel
  import gpio_fsel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsel_wr_i,
  input  logic               all_a_i,
  input  logic               all_b_i,
  output logic               sel_b_o,
  input  logic               ha_clk_i,
  input  logic               ha_cmd_i,
  input  logic [CARD_DW-1:0] ha_dat_i,
  input  logic               hb_clk_i,
  input  logic               hb_cmd_i,
  input  logic [CARD_DW-1:0] hb_dat_i,
  input  logic               card_cmd_i,
  input  logic [CARD_DW-1:0] card_dat_i,
  output logic               card_clk_o,
  output logic               card_cmd_o,
  output logic [CARD_DW-1:0] card_dat_o,
  output logic               ha_cmd_o,
  output logic [CARD_DW-1:0] ha_dat_o,
  output logic               hb_cmd_o,
  output logic [CARD_DW-1:0] hb_dat_o
);
  logic eval_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      eval_q <= fsel_wr_i;
      if (eval_q) begin
        if (sel_q && all_a_i)       sel_q <= 1'b0;
        else if (!sel_q && all_b_i) sel_q <= 1'b1;
      end
    end
  end

  assign sel_b_o    = sel_q;
  assign card_clk_o = sel_q ? hb_clk_i : ha_clk_i;
  assign card_cmd_o = sel_q ? hb_cmd_i : ha_cmd_i;
  assign card_dat_o = sel_q ? hb_dat_i : ha_dat_i;
  assign ha_cmd_o   = sel_q ? 1'b1 : card_cmd_i;
  assign ha_dat_o   = sel_q ? '1   : card_dat_i;
  assign hb_cmd_o   = sel_q ? card_cmd_i : 1'b1;
  assign hb_dat_o   = sel_q ? card_dat_i : '1;
endmodule

// File: rtl/gpio_fsel_ctrl.sv
module gpio_fsel_ctrl
  import gpio_fsel_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                rvalid_o,
  output logic                err_o,
  output logic [NUM_PINS-1:0] pin_o,
  output logic                sel_b_o,
  input  logic                ha_clk_i,
  input  logic                ha_cmd_i,
  input  logic [CARD_DW-1:0]  ha_dat_i,
  input  logic                hb_clk_i,
  input  logic                hb_cmd_i,
  input  logic [CARD_DW-1:0]  hb_dat_i,
  input  logic                card_cmd_i,
  input  logic [CARD_DW-1:0]  card_dat_i,
  output logic                card_clk_o,
  output logic                card_cmd_o,
  output logic [CARD_DW-1:0]  card_dat_o,
  output logic                ha_cmd_o,
  output logic [CARD_DW-1:0]  ha_dat_o,
  output logic                hb_cmd_o,
  output logic [CARD_DW-1:0]  hb_dat_o
);
  acc_kind_e           kind;
  logic [IDXW-1:0]     idx;
  logic                wr, fsel_wr;
  logic [DW-1:0]       fsel_word, rd_val, rdata_q;
  logic [NUM_PINS-1:0] is_out;
  logic                all_a, all_b;
  logic [LOW_W-1:0]    lev_lo, pin_lo;
  logic [HIGH_W-1:0]   lev_hi, pin_hi;
  logic                rvalid_q, err_q;

  gpio_addr_dec u_dec (.addr_i(addr_i), .kind_o(kind), .idx_o(idx));

  assign wr      = req_i && we_i;
  assign fsel_wr = wr && (kind == ACC_FSEL);

  gpio_fsel_regs u_fsel (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(fsel_wr), .idx_i(idx),
    .wdata_i(wdata_i[FPW*FW-1:0]), .rword_o(fsel_word), .is_out_o(is_out),
    .card_all_a_o(all_a), .card_all_b_o(all_b)
  );

  gpio_level_bank #(.W(LOW_W)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(wr && kind == ACC_SET_LO), .clr_i(wr && kind == ACC_CLR_LO),
    .wdata_i(wdata_i[LOW_W-1:0]), .is_out_i(is_out[LOW_W-1:0]),
    .lev_o(lev_lo), .pin_o(pin_lo)
  );

  gpio_level_bank #(.W(HIGH_W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(wr && kind == ACC_SET_HI), .clr_i(wr && kind == ACC_CLR_HI),
    .wdata_i(wdata_i[HIGH_W-1:0]), .is_out_i(is_out[NUM_PINS-1:LOW_W]),
    .lev_o(lev_hi), .pin_o(pin_hi)
  );

  assign pin_o = {pin_hi, pin_lo};

  gpio_card_sel u_card (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsel_wr_i(fsel_wr),
    .all_a_i(all_a), .all_b_i(all_b), .sel_b_o(sel_b_o),
    .ha_clk_i(ha_clk_i), .ha_cmd_i(ha_cmd_i), .ha_dat_i(ha_dat_i),
    .hb_clk_i(hb_clk_i), .hb_cmd_i(hb_cmd_i), .hb_dat_i(hb_dat_i),
    .card_cmd_i(card_cmd_i), .card_dat_i(card_dat_i),
    .card_clk_o(card_clk_o), .card_cmd_o(card_cmd_o), .card_dat_o(card_dat_o),
    .ha_cmd_o(ha_cmd_o), .ha_dat_o(ha_dat_o),
    .hb_cmd_o(hb_cmd_o), .hb_dat_o(hb_dat_o)
  );

  always_comb begin
    unique case (kind)
      ACC_FSEL:   rd_val = fsel_word;
      ACC_LEV_LO: rd_val = DW'(lev_lo);
      ACC_LEV_HI: rd_val = DW'(lev_hi);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      err_q    <= req_i && (kind == ACC_BAD);
      rdata_q  <= (req_i && !we_i) ? rd_val : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/gpio_fsel_chk.sv
module gpio_fsel_chk
  import gpio_fsel_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [AW-1:0]       addr_i,
  input logic [DW-1:0]       wdata_i,
  input logic                rvalid_o,
  input logic                err_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic                sel_b_o,
  input logic                ha_cmd_o,
  input logic [CARD_DW-1:0]  ha_dat_o,
  input logic                hb_cmd_o,
  input logic [CARD_DW-1:0]  hb_dat_o,
  input logic [NUM_PINS-1:0] is_out_i,
  input logic [LOW_W-1:0]    lev_lo_i,
  input logic [HIGH_W-1:0]   lev_hi_i
);
  logic fsel_strobe, rsvd_wr;
  assign fsel_strobe = req_i && we_i && addr_i[1:0] == 2'b00 && addr_i <= OFS_FSEL_LAST;
  assign rsvd_wr = req_i && we_i && addr_i[1:0] == 2'b00 &&
                   addr_i >= OFS_RSVD_LO && addr_i <= OFS_RSVD_HI;

  p_set_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_SET_LO) |=>
      ((lev_lo_i & $past(wdata_i[LOW_W-1:0])) == $past(wdata_i[LOW_W-1:0])));

  p_clr_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_CLR_HI) |=>
      ((lev_hi_i & $past(wdata_i[HIGH_W-1:0])) == '0));

  p_lev_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i == OFS_LEV_LO || addr_i == OFS_LEV_HI)) |=>
      ($stable(lev_lo_i) && $stable(lev_hi_i) && $stable(pin_o)));

  p_pin_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ $past(pin_o)) & ~$past(is_out_i)) == '0);

  p_rsvd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_wr |=> (!err_o && $stable(pin_o) && $stable(lev_lo_i) && $stable(lev_hi_i)));

  p_unaligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> err_o);

  p_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_sel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_b_o) |-> $past(fsel_strobe, 2));

  p_idle_b_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_b_o |-> (hb_cmd_o && (&hb_dat_o)));

  p_idle_a_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_b_o |-> (ha_cmd_o && (&ha_dat_o)));
endmodule

bind gpio_fsel_ctrl gpio_fsel_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .err_o(err_o),
  .pin_o(pin_o), .sel_b_o(sel_b_o), .ha_cmd_o(ha_cmd_o), .ha_dat_o(ha_dat_o),
  .hb_cmd_o(hb_cmd_o), .hb_dat_o(hb_dat_o), .is_out_i(is_out),
  .lev_lo_i(lev_lo), .lev_hi_i(lev_hi)
);

// File: tb/sim_gpio_fsel_ctrl.sv
module sim_gpio_fsel_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, err_o, sel_b_o;
  logic [53:0] pin_o;
  logic        ha_clk_i = 0, ha_cmd_i = 0, hb_clk_i = 0, hb_cmd_i = 0, card_cmd_i = 0;
  logic [3:0]  ha_dat_i = 0, hb_dat_i = 0, card_dat_i = 0;
  logic        card_clk_o, card_cmd_o, ha_cmd_o, hb_cmd_o;
  logic [3:0]  card_dat_o, ha_dat_o, hb_dat_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0]  m_fsel [54];
  logic [53:0] m_lev, m_pin;
  logic        m_sel;

  always #5 clk_i = ~clk_i;

  gpio_fsel_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [11:0] a);
    if (a[1:0] != 0) return 1;
    if (a <= 12'h014) return 0;
    if (a >= 12'h040 && a <= 12'h09C) return 0;
    if (a == 12'h01C || a == 12'h020 || a == 12'h028 || a == 12'h02C ||
        a == 12'h034 || a == 12'h038) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] w = '0;
    if (a[1:0] != 0) return '0;
    if (a <= 12'h014) begin
      for (int f = 0; f < 10; f++)
        if (int'(a[4:2]) * 10 + f < 54) w[f*3 +: 3] = m_fsel[int'(a[4:2]) * 10 + f];
      return w;
    end
    if (a == 12'h034) return m_lev[31:0];
    if (a == 12'h038) return {10'b0, m_lev[53:32]};
    return '0;
  endfunction

  function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
    logic [53:0] nl;
    bit a0, b4;
    if (exp_bad(a)) return;
    if (a <= 12'h014) begin
      for (int f = 0; f < 10; f++)
        if (int'(a[4:2]) * 10 + f < 54) m_fsel[int'(a[4:2]) * 10 + f] = d[f*3 +: 3];
      a0 = 1; b4 = 1;
      for (int c = 48; c < 54; c++) begin
        if (m_fsel[c] != 0) a0 = 0;
        if (m_fsel[c] != 4) b4 = 0;
      end
      if (m_sel && a0) m_sel = 0;
      else if (!m_sel && b4) m_sel = 1;
      return;
    end
    nl = m_lev;
    case (a)
      12'h01C: nl[31:0]  = m_lev[31:0]  | d;
      12'h020: nl[53:32] = m_lev[53:32] | d[21:0];
      12'h028: nl[31:0]  = m_lev[31:0]  & ~d;
      12'h02C: nl[53:32] = m_lev[53:32] & ~d[21:0];
      default: ;
    endcase
    for (int p = 0; p < 54; p++)
      if (nl[p] != m_lev[p] && m_fsel[p] == 1) m_pin[p] = nl[p];
    m_lev = nl;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (exp_bad(a)) return "R8";
    if (a <= 12'h00C) return "R1";
    if (a <= 12'h014) return "R2";
    if (a == 12'h01C || a == 12'h020) return "R3";
    if (a == 12'h028 || a == 12'h02C) return "R4";
    if (a == 12'h034 || a == 12'h038) return "R5";
    return "R7";
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    chk(err_o == exp_bad(a), "R8 err after write", 64'(err_o), 64'(exp_bad(a)));
    model_wr(a, d);
    @(negedge clk_i);
    chk(pin_o == m_pin, "R6 pins", 64'(pin_o), 64'(m_pin));
    chk(sel_b_o == m_sel, "R10 selector", 64'(sel_b_o), 64'(m_sel));
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    chk(rvalid_o == 1'b1, "R9 rvalid", 64'(rvalid_o), 64'd1);
    chk(rdata_o == exp_rd(a), {tag_of(a), " read"}, 64'(rdata_o), 64'(exp_rd(a)));
    chk(err_o == exp_bad(a), "R8 err after read", 64'(err_o), 64'(exp_bad(a)));
    @(negedge clk_i);
    chk(rvalid_o == 1'b0, "R9 rvalid one cycle", 64'(rvalid_o), 64'd0);
  endtask

  task automatic card_chk();
    {ha_clk_i, ha_cmd_i, ha_dat_i} = 6'($urandom);
    {hb_clk_i, hb_cmd_i, hb_dat_i} = 6'($urandom);
    {card_cmd_i, card_dat_i} = 5'($urandom);
    #1;
    if (m_sel) begin
      chk({card_clk_o, card_cmd_o, card_dat_o} == {hb_clk_i, hb_cmd_i, hb_dat_i}, "R11 card from B",
          64'({card_clk_o, card_cmd_o, card_dat_o}), 64'({hb_clk_i, hb_cmd_i, hb_dat_i}));
      chk({hb_cmd_o, hb_dat_o, ha_cmd_o, ha_dat_o} == {card_cmd_i, card_dat_i, 5'h1F}, "R11 returns B",
          64'({hb_cmd_o, hb_dat_o, ha_cmd_o, ha_dat_o}), 64'({card_cmd_i, card_dat_i, 5'h1F}));
    end else begin
      chk({card_clk_o, card_cmd_o, card_dat_o} == {ha_clk_i, ha_cmd_i, ha_dat_i}, "R11 card from A",
          64'({card_clk_o, card_cmd_o, card_dat_o}), 64'({ha_clk_i, ha_cmd_i, ha_dat_i}));
      chk({ha_cmd_o, ha_dat_o, hb_cmd_o, hb_dat_o} == {card_cmd_i, card_dat_i, 5'h1F}, "R11 returns A",
          64'({ha_cmd_o, ha_dat_o, hb_cmd_o, hb_dat_o}), 64'({card_cmd_i, card_dat_i, 5'h1F}));
    end
  endtask

  function automatic logic [31:0] rand_fsel();
    logic [31:0] d = $urandom;
    for (int f = 0; f < 10; f++)
      case ($urandom % 4)
        0: d[f*3 +: 3] = 3'd0;
        1: d[f*3 +: 3] = 3'd1;
        2: d[f*3 +: 3] = 3'd4;
        default: ;
      endcase
    return d;
  endfunction

  function automatic logic [11:0] rand_addr();
    case ($urandom % 8)
      0, 1: return 12'(($urandom % 6) * 4);
      2: return ($urandom % 2) ? 12'h01C : 12'h020;
      3: return ($urandom % 2) ? 12'h028 : 12'h02C;
      4: return ($urandom % 2) ? 12'h034 : 12'h038;
      5: return 12'h040 + 12'(($urandom % 24) * 4);
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 54; p++) m_fsel[p] = 0;
    m_lev = '0; m_pin = '0; m_sel = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R12 reset state
    chk(pin_o == '0, "R12 pins at reset", 64'(pin_o), 64'd0);
    chk(sel_b_o == 1'b0, "R12 host A at reset", 64'(sel_b_o), 64'd0);
    for (int r = 0; r < 6; r++) rd(12'(r * 4));
    rd(12'h034); rd(12'h038);
    card_chk();

    // R1/R2 layout and unmapped fields
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000);
    wr(12'h014, 32'hFFFF_FFFF); rd(12'h014);
    // R6 output pin gating
    wr(12'h000, 32'h0000_0249);           // pins 0..3 output
    wr(12'h01C, 32'h0000_00FF); rd(12'h034);
    wr(12'h028, 32'h0000_0003);
    wr(12'h000, 32'h0000_0000);           // code change alone leaves pins
    wr(12'h028, 32'h0000_00FF); rd(12'h034);
    // R3/R4 high bank, write-only reads
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h038);
    rd(12'h01C); rd(12'h020); rd(12'h028); rd(12'h02C);
    wr(12'h02C, 32'h0015_5555); rd(12'h038);
    // R5 writes to level ignored
    wr(12'h034, 32'h0); wr(12'h038, 32'h0); rd(12'h034); rd(12'h038);
    // R7 reserved, R8 bad offsets
    wr(12'h040, 32'hFFFF_FFFF); wr(12'h09C, 32'hFFFF_FFFF); rd(12'h094);
    rd(12'h018); rd(12'h024); rd(12'h030); rd(12'h03C); rd(12'h0A0); rd(12'h001);
    wr(12'h0A0, 32'hFFFF_FFFF); wr(12'h01E, 32'hFFFF_FFFF); rd(12'h034);
    // R10 selector sequences
    wr(12'h014, 32'h0000_0924);           // pins 50..53 code 4
    wr(12'h010, 32'h2400_0000);           // pins 48,49 code 4 -> B
    card_chk();
    wr(12'h010, 32'h0000_0000);           // mixed -> hold B
    wr(12'h014, 32'h0000_0000);           // all 0 -> A
    card_chk();

    for (int i = 0; i < 1500; i++) begin
      logic [11:0] a;
      a = rand_addr();
      case ($urandom % 3)
        0: rd(a);
        default: wr(a, (a <= 12'h014) ? rand_fsel() : $urandom);
      endcase
      if (i % 50 == 0) begin
        wr(12'h010, ($urandom % 2) ? 32'h2400_0000 : 32'h0);
        wr(12'h014, ($urandom % 2) ? 32'h0000_0924 : 32'h0);
        card_chk();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule